// File: doc/BRIEF.md
# Stride-Interleave DMA Address Generator

This block drives the address side of an interleaved DMA transfer between main memory and a scratchpad. Software gives it a start memory address, a start scratchpad address, a total quadword count, a slice length and a gap length. The block then breaks the transfer into slices and hands them to a data mover one at a time. For each slice it gives the length and both byte addresses, and it waits until the mover reports the slice done. The scratchpad side is packed tightly. The memory side jumps over a gap of quadwords after every slice.

The generator does not care which way the data flows, so one copy can serve either direction. A slice length of zero means the whole count goes in a single slice. When the count does not divide evenly, the last slice is shorter. After the transfer ends, the block flags completion, shows a remaining count of zero and holds the final addresses on its address outputs.

Top module: `sid_addr_gen`

## Requirements
- R1: While reset is held and on the first cycle after it, `req_valid`, `xfer_done` and `remain_qw` are all zero, and both address outputs are zero.
- R2: A `start` pulse in idle with a nonzero total raises `req_valid` on the next cycle. At that point `cur_mem_addr` and `cur_spr_addr` equal the start addresses, and `remain_qw` equals the total.
- R3: Every request's `req_len` is the smaller of the latched slice length and the remaining count. The remaining count drops by `req_len` when the slice is acknowledged, so only the final slice can be short.
- R4: A slice length of zero at start makes a single request whose length equals the total count.
- R5: Each acknowledged slice moves `cur_spr_addr` forward by `req_len` × 16 bytes, wrapping modulo 2^ADDR_W.
- R6: Each acknowledged slice moves `cur_mem_addr` forward by (gap + `req_len`) × 16 bytes, wrapping modulo 2^ADDR_W. This includes the final slice.
- R7: While `req_valid` is high and `req_done` is low, `req_len`, both addresses and `remain_qw` do not change.
- R8: On the cycle after the final slice is acknowledged, `req_valid` is 0, `xfer_done` is 1 and `remain_qw` is 0. `xfer_done` stays at 1 until the next accepted start.
- R9: A start with a total of zero sets `xfer_done` on the next cycle and issues no request. The addresses stay at the start values.
- R10: A `start` pulse while a transfer is running is ignored: the current request, the addresses and the remaining count are unchanged.
- R11: The slice and gap lengths are sampled at start. Changing those inputs during a transfer has no effect on it.
- R12: After completion, `cur_mem_addr` and `cur_spr_addr` hold the final addresses until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (accepted only in idle) |
| start_mem_addr | input | ADDR_W | Memory-side start byte address |
| start_spr_addr | input | ADDR_W | Scratchpad-side start byte address |
| total_qw | input | CNT_W | Total quadwords to move |
| slice_qw | input | CNT_W | Quadwords per slice; 0 means all in one slice |
| gap_qw | input | CNT_W | Quadwords skipped on the memory side after each slice |
| req_valid | output | 1 | A slice request is presented |
| req_len | output | CNT_W | Quadwords in the current slice |
| cur_mem_addr | output | ADDR_W | Memory byte address of the slice; final address after completion |
| cur_spr_addr | output | ADDR_W | Scratchpad byte address of the slice; final address after completion |
| req_done | input | 1 | Mover acknowledges the current slice |
| remain_qw | output | CNT_W | Quadwords not yet acknowledged |
| xfer_done | output | 1 | Transfer finished, held until next start |

## Verification
Every result is due exactly one clock edge after its cause. A start shows up as the first request or, for a zero count, as the done flag. An acknowledged slice shows up as the next slice's length and addresses or as completion. The bench changes inputs on falling edges and reads the outputs on the next falling edge, half a period after the rising edge that registers them. It compares them with addresses and lengths it works out itself from the start values. While a request waits for its acknowledge, the bench samples it on every falling edge to confirm that nothing moves. It also pokes `start` and the slice and gap inputs during that wait.

// File: rtl/sid_pkg.sv
package sid_pkg;
  parameter int SID_ADDR_W_DEF = 32;
  parameter int SID_CNT_W_DEF  = 16;
  parameter int SID_QW_BYTES   = 16;

  typedef enum logic [0:0] {
    SID_IDLE  = 1'b0,
    SID_ISSUE = 1'b1
  } sid_state_e;
endpackage

// File: rtl/sid_slice_calc.sv
module sid_slice_calc #(
  parameter int CNT_W = sid_pkg::SID_CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] slice_held,
  input  logic [CNT_W-1:0] remain,
  output logic [CNT_W-1:0] len,
  output logic             is_last
);
  function automatic logic [CNT_W-1:0] min_len(input logic [CNT_W-1:0] a,
                                              input logic [CNT_W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  assign len     = min_len(slice_held, remain);
  assign is_last = (len == remain);

  // R3: a live slice never exceeds what is left and never stalls at zero length
  a_r3_len_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (remain != '0 && slice_held != '0) |-> (len != '0 && len <= remain && len <= slice_held));
endmodule

// File: rtl/sid_addr_step.sv
module sid_addr_step #(
  parameter int ADDR_W = sid_pkg::SID_ADDR_W_DEF,
  parameter int CNT_W  = sid_pkg::SID_CNT_W_DEF,
  parameter int QW_B   = sid_pkg::SID_QW_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              step,
  input  logic [CNT_W-1:0]  len,
  input  logic [CNT_W-1:0]  gap,
  output logic [ADDR_W-1:0] addr
);
  localparam int SHIFT = $clog2(QW_B);

  function automatic logic [ADDR_W-1:0] step_bytes(input logic [CNT_W-1:0] g,
                                                   input logic [CNT_W-1:0] l);
    logic [CNT_W:0] qw;
    qw = {1'b0, g} + {1'b0, l};
    return ADDR_W'(qw) << SHIFT;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)    addr <= '0;
    else if (load) addr <= load_addr;
    else if (step) addr <= addr + step_bytes(gap, len);
  end

  // R7: the address only moves on a load or a step
  a_r7_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(addr));
endmodule

// File: rtl/sid_ctrl.sv
module sid_ctrl #(
  parameter int CNT_W = sid_pkg::SID_CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] total_qw,
  input  logic [CNT_W-1:0] slice_qw,
  input  logic [CNT_W-1:0] gap_qw,
  input  logic             req_done,
  input  logic [CNT_W-1:0] len,
  input  logic             is_last,
  output logic             start_acc,
  output logic             advance,
  output logic             issuing,
  output logic             done_q,
  output logic [CNT_W-1:0] rem_q,
  output logic [CNT_W-1:0] slice_q,
  output logic [CNT_W-1:0] gap_q
);
  import sid_pkg::*;

  sid_state_e st;

  function automatic logic [CNT_W-1:0] eff_slice(input logic [CNT_W-1:0] s,
                                                 input logic [CNT_W-1:0] t);
    return (s == '0) ? t : s;
  endfunction

  assign issuing   = (st == SID_ISSUE);
  assign start_acc = start && (st == SID_IDLE);
  assign advance   = issuing && req_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= SID_IDLE;
      rem_q   <= '0;
      slice_q <= '0;
      gap_q   <= '0;
      done_q  <= 1'b0;
    end else if (start_acc) begin
      rem_q   <= total_qw;
      slice_q <= eff_slice(slice_qw, total_qw);
      gap_q   <= gap_qw;
      done_q  <= (total_qw == '0);
      st      <= (total_qw == '0) ? SID_IDLE : SID_ISSUE;
    end else if (advance) begin
      rem_q <= rem_q - len;
      if (is_last) begin
        st     <= SID_IDLE;
        done_q <= 1'b1;
      end
    end
  end

  // R8: completion always comes with an empty count
  a_r8_done_empty: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (rem_q == '0 && !issuing));
  // R7: a waiting request keeps its count
  a_r7_wait_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (issuing && !req_done) |=> (issuing && $stable(rem_q)));
  // R10 / R11: start while busy leaves the sampled fields alone
  a_r10_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (issuing && start) |=> ($stable(slice_q) && $stable(gap_q)));
endmodule

// File: rtl/sid_addr_gen.sv
module sid_addr_gen #(
  parameter int ADDR_W = sid_pkg::SID_ADDR_W_DEF,
  parameter int CNT_W  = sid_pkg::SID_CNT_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_mem_addr,
  input  logic [ADDR_W-1:0] start_spr_addr,
  input  logic [CNT_W-1:0]  total_qw,
  input  logic [CNT_W-1:0]  slice_qw,
  input  logic [CNT_W-1:0]  gap_qw,
  output logic              req_valid,
  output logic [CNT_W-1:0]  req_len,
  output logic [ADDR_W-1:0] cur_mem_addr,
  output logic [ADDR_W-1:0] cur_spr_addr,
  input  logic              req_done,
  output logic [CNT_W-1:0]  remain_qw,
  output logic              xfer_done
);
  localparam int NSIDE = 2;  // 0: memory side, 1: scratchpad side
  localparam int SHIFT = $clog2(sid_pkg::SID_QW_BYTES);

  logic             start_acc, advance, issuing, done_q, is_last;
  logic [CNT_W-1:0] rem_q, slice_q, gap_q, len;

  logic [ADDR_W-1:0] side_load [NSIDE];
  logic [CNT_W-1:0]  side_gap  [NSIDE];
  logic [ADDR_W-1:0] side_addr [NSIDE];

  sid_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .total_qw(total_qw),
    .slice_qw(slice_qw), .gap_qw(gap_qw), .req_done(req_done),
    .len(len), .is_last(is_last), .start_acc(start_acc), .advance(advance),
    .issuing(issuing), .done_q(done_q), .rem_q(rem_q), .slice_q(slice_q),
    .gap_q(gap_q)
  );

  sid_slice_calc #(.CNT_W(CNT_W)) u_calc (
    .clk(clk), .rst_n(rst_n), .slice_held(slice_q), .remain(rem_q),
    .len(len), .is_last(is_last)
  );

  assign side_load[0] = start_mem_addr;
  assign side_load[1] = start_spr_addr;
  assign side_gap[0]  = gap_q;
  assign side_gap[1]  = '0;

  for (genvar i = 0; i < NSIDE; i++) begin : g_side
    sid_addr_step #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_step (
      .clk(clk), .rst_n(rst_n), .load(start_acc), .load_addr(side_load[i]),
      .step(advance), .len(len), .gap(side_gap[i]), .addr(side_addr[i])
    );
  end

  assign req_valid    = issuing;
  assign req_len      = issuing ? len : '0;
  assign cur_mem_addr = side_addr[0];
  assign cur_spr_addr = side_addr[1];
  assign remain_qw    = rem_q;
  assign xfer_done    = done_q;

  // R5: packed side steps by the slice alone
  a_r5_spr_step: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> cur_spr_addr == $past(cur_spr_addr) + (ADDR_W'($past(req_len)) << SHIFT));
  // R6: memory side steps by slice plus gap
  a_r6_mem_step: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> cur_mem_addr == $past(cur_mem_addr)
                 + ((ADDR_W'($past(req_len)) + ADDR_W'($past(gap_q))) << SHIFT));
  // R2: an accepted nonzero start presents the start addresses
  a_r2_first_req: assert property (@(posedge clk) disable iff (!rst_n)
    (start_acc && total_qw != '0) |=> (req_valid && cur_mem_addr == $past(start_mem_addr)
                                       && cur_spr_addr == $past(start_spr_addr)));
  // R8: request and completion are never shown together
  a_r8_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && xfer_done));
  // R12: final addresses hold while finished and idle
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !start) |=> ($stable(cur_mem_addr) && $stable(cur_spr_addr)));
endmodule

// File: tb/sid_addr_gen_bench.sv
module sid_addr_gen_bench;
  localparam int AW = 32;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] start_mem_addr = '0, start_spr_addr = '0;
  logic [CW-1:0] total_qw = '0, slice_qw = '0, gap_qw = '0;
  logic          req_done = 1'b0;
  logic          req_valid, xfer_done;
  logic [CW-1:0] req_len, remain_qw;
  logic [AW-1:0] cur_mem_addr, cur_spr_addr;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sid_addr_gen #(.ADDR_W(AW), .CNT_W(CW)) u_sid_addr_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .start_mem_addr(start_mem_addr),
    .start_spr_addr(start_spr_addr), .total_qw(total_qw), .slice_qw(slice_qw),
    .gap_qw(gap_qw), .req_valid(req_valid), .req_len(req_len),
    .cur_mem_addr(cur_mem_addr), .cur_spr_addr(cur_spr_addr),
    .req_done(req_done), .remain_qw(remain_qw), .xfer_done(xfer_done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Runs one transfer; hold = idle cycles before each acknowledge,
  // poke = pulse start and alter slice/gap inputs while the first slice waits.
  task automatic run_xfer(input logic [AW-1:0] m0, input logic [AW-1:0] s0,
                          input int total, input int slice, input int gap,
                          input int hold, input bit poke);
    logic [AW-1:0] em, es;
    int rem, eff, ln, nslices;
    string tl;
    @(negedge clk);
    start_mem_addr = m0; start_spr_addr = s0;
    total_qw = CW'(total); slice_qw = CW'(slice); gap_qw = CW'(gap);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R11: disturb the sampled fields right after start
    slice_qw = 16'd1; gap_qw = 16'd99;
    em = m0; es = s0; rem = total;
    eff = (slice == 0) ? total : slice;
    tl = (slice == 0) ? "R4" : "R3";
    nslices = 0;
    if (total == 0) begin
      chk(xfer_done === 1'b1, "R9", "done on zero count", 64'(xfer_done), 1);
      chk(req_valid === 1'b0, "R9", "no request", 64'(req_valid), 0);
      chk(cur_mem_addr === m0 && cur_spr_addr === s0, "R9", "addresses kept",
          {cur_mem_addr, cur_spr_addr}, {m0, s0});
      return;
    end
    chk(remain_qw === CW'(total), "R2", "remain after start", 64'(remain_qw), 64'(total));
    while (rem > 0) begin
      ln = (eff < rem) ? eff : rem;
      chk(req_valid === 1'b1, "R2", "req_valid", 64'(req_valid), 1);
      chk(req_len === CW'(ln), tl, "slice length", 64'(req_len), 64'(ln));
      chk(cur_mem_addr === em, "R6", "mem addr", 64'(cur_mem_addr), 64'(em));
      chk(cur_spr_addr === es, "R5", "spr addr", 64'(cur_spr_addr), 64'(es));
      for (int h = 0; h < hold; h++) begin
        if (poke && nslices == 0 && h == 0) start = 1'b1;
        start_mem_addr = m0 ^ 32'h0F00_0000;
        @(negedge clk);
        start = 1'b0;
        chk(req_valid === 1'b1 && req_len === CW'(ln) && cur_mem_addr === em &&
            cur_spr_addr === es && remain_qw === CW'(rem),
            (poke && nslices == 0) ? "R10" : "R7", "request held",
            {cur_mem_addr, 16'(req_len), 16'(remain_qw)}, {em, 16'(ln), 16'(rem)});
      end
      req_done = 1'b1;
      @(negedge clk);
      req_done = 1'b0;
      rem -= ln;
      es += AW'(ln * 16);
      em += AW'((gap + ln) * 16);
      nslices++;
    end
    chk(req_valid === 1'b0 && xfer_done === 1'b1, "R8", "completion",
        {62'd0, req_valid, xfer_done}, 64'd1);
    chk(remain_qw === '0, "R8", "remain zero", 64'(remain_qw), 0);
    chk(cur_mem_addr === em && cur_spr_addr === es, "R12", "final addresses",
        {cur_mem_addr, cur_spr_addr}, {em, es});
    @(negedge clk);
    chk(xfer_done === 1'b1 && cur_mem_addr === em && cur_spr_addr === es, "R12",
        "final state held", {cur_mem_addr, cur_spr_addr}, {em, es});
    if (slice != 0 && slice < total)
      chk(nslices == (total + slice - 1) / slice, "R11", "slice count",
          64'(nslices), 64'((total + slice - 1) / slice));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_valid === 1'b0 && xfer_done === 1'b0 && remain_qw === '0 &&
        cur_mem_addr === '0 && cur_spr_addr === '0, "R1", "reset state",
        {req_valid, xfer_done, 14'd0, remain_qw, cur_mem_addr}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_valid === 1'b0 && xfer_done === 1'b0, "R1", "idle after reset",
        {62'd0, req_valid, xfer_done}, 0);
    run_xfer(32'h0010_0000, 32'h0000_0200, 12, 4, 2, 1, 1'b0);  // even split
    run_xfer(32'h0020_0040, 32'h0000_0000, 10, 4, 3, 0, 1'b0);  // short tail
    run_xfer(32'h0030_0000, 32'h0000_1000, 7, 0, 5, 2, 1'b0);   // zero slice
    run_xfer(32'h0040_0000, 32'h0000_0010, 3, 8, 1, 0, 1'b0);   // slice > total
    run_xfer(32'h0050_0000, 32'h0000_0030, 0, 4, 2, 0, 1'b0);   // zero count
    run_xfer(32'h0060_0000, 32'h0000_0400, 9, 2, 6, 3, 1'b1);   // busy start poke
    run_xfer(32'hFFFF_FFC0, 32'hFFFF_FFE0, 5, 2, 1, 1, 1'b0);   // address wrap
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule